// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block puts the command interface of a parallel NOR flash in front of a small on-chip memory array. The array is reached through a simple synchronous bus. Every bus write is treated as one cycle of a command sequence. A two-bit cycle counter and a latched command byte decide whether the written byte is a new opcode, a confirm code, a word count or payload data. The sequences cover word program, block erase, lock/unlock, buffered write, status clearing and mode selection.

Every bus read is answered one clock later. The source of the answer follows the latched command:
- array contents in read-array mode;
- the status byte, repeated in each device lane, while a program, erase, lock, clear, status or buffered-write command is current;
- a word supplied by an external responder in identify and query modes.

The responder holds the identify and query tables. The sequencer only forwards the request and returns the responder's word. A read-only configuration pin blocks every change to the array and sets fault bits in status instead. Block erase runs as a background walk of one word per clock. The block ignores all bus traffic until the walk has finished.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode with cycle count 0 and status 0x80, `rvalid` and `busy` are low, and a status read returns 0x80 in every lane.
- R2: At cycle 0 a write whose low byte is 0x00, 0xF0 or 0xFF selects read-array mode, after which reads return array words.
- R3: Opcode 0x10 or 0x40 arms a program. The next write stores its full word at the word holding the byte offset and sets status bit 7 (0x80). When `ro_cfg` is high the array is left unchanged and status bit 4 (0x10) is set as well.
- R4: Opcode 0x20 fills every word of the BLK_BYTES-aligned block that holds the offset with all ones, one word per clock, with `busy` high for exactly BLK_BYTES/bytes-per-word cycles, and sets 0x80. The next write must be 0xD0, which ends the sequence in status mode. Any other byte returns to read-array mode. When `ro_cfg` is high nothing is erased, `busy` stays low and status bit 5 (0x20) is set.
- R5: Opcode 0x50 clears the whole status byte to 0x00 and selects read-array mode.
- R6: While the command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, reads return the status byte in the low byte of every device-width lane of the word, with the other bits zero.
- R7: Opcode 0x90 (identify) and opcode 0x98 (query) forward reads to the responder. `qry_sel` is 0 for identify and 1 for query, and the responder's word is returned. Query mode stays selected through further writes until one carries 0xFF.
- R8: Opcode 0x60 arms lock/unlock. A following 0xD0 or 0x01 completes it with 0x80 set and stays in status mode. Any other byte, 0xFF included, returns to read-array mode.
- R9: Opcode 0xE8 sets 0x80 and starts a buffered write. The next write loads a word count, masked to the device width (the bank width when DEV_BYTES is 0). Exactly count+1 data writes follow, each stored at its own offset. Then a 0xD0 ends the sequence in status mode and any other byte returns to read-array mode. When `ro_cfg` is high the data writes leave the array unchanged and set 0x10.
- R10: At cycle 0 an opcode outside the set above selects read-array mode.
- R11: `rvalid` is high exactly one cycle after an accepted read, and `rdata` holds the answer in that cycle.
- R12: While `busy` is high, reads and writes are ignored: no `rvalid` and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data; low byte is the command byte |
| ro_cfg | input | 1 | Read-only configuration: blocks array changes |
| rdata | output | DATA_W | Read answer, valid with rvalid |
| rvalid | output | 1 | Read answer valid, one cycle after the read |
| busy | output | 1 | Block erase in progress; bus is ignored |
| qry_req | output | 1 | Identify/query read forwarded to responder |
| qry_sel | output | 1 | 0 = identify, 1 = query |
| qry_addr | output | ADDR_W | Byte offset forwarded to responder |
| qry_data | input | DATA_W | Responder word, returned combinationally |

## Verification
The bench runs every sequence against a behavioural model and compares `busy`, `rvalid` and `rdata` on each clock. It covers the confirm and abort branch of every multi-cycle sequence. A design that left the mode as it was on an abort byte would return status where array words are expected. A count that was not masked, or a decrement that was off by one, would store one word too many or too few in a buffered write. A design that let a read through while an erase was still walking would answer when it should stay silent. The read-only pin is exercised on program, erase and buffered write, so a design that raised the wrong fault bit, or that still changed the array, would show a wrong status word or a changed array word.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam logic [7:0] OP_RD_ARRAY  = 8'h00;
  localparam logic [7:0] OP_RD_ALT    = 8'hF0;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_ERASE_ALT = 8'h28;
  localparam logic [7:0] OP_CLR       = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STAT      = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_BUFWR     = 8'hE8;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT  = 8'h01;

  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  typedef enum logic [1:0] {
    RS_ARRAY,
    RS_STATUS,
    RS_QUERY
  } rsrc_t;

  function automatic logic shows_status(input logic [7:0] c);
    return (c == OP_PROG_A) || (c == OP_PROG_B) || (c == OP_ERASE) ||
           (c == OP_ERASE_ALT) || (c == OP_CLR) || (c == OP_LOCK) ||
           (c == OP_STAT) || (c == OP_BUFWR);
  endfunction

  function automatic logic known_opcode(input logic [7:0] c);
    return (c == OP_RD_ARRAY) || (c == OP_RD_ALT) || (c == OP_RESET) ||
           (c == OP_PROG_A) || (c == OP_PROG_B) || (c == OP_ERASE) ||
           (c == OP_CLR) || (c == OP_LOCK) || (c == OP_STAT) ||
           (c == OP_IDENT) || (c == OP_QUERY) || (c == OP_BUFWR);
  endfunction
endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int DATA_W = 16,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nor_erase_walker.sv
module nor_erase_walker #(
  parameter int AW        = 7,
  parameter int BLK_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic [AW-1:0] wr_addr
);
  localparam int IW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(BLK_WORDS - 1);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BLK_WORDS - 1);

  logic [AW-1:0] base_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      base_q <= start_addr & ALIGN_MASK;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign wr_addr = base_q | AW'(idx_q);

  assert_walk_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q == LAST) |=> !busy_q);
  assert_walk_from_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (idx_q == '0));
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_acc,
  input  logic [CNT_W-1:0] wword,
  input  logic             ro,
  output logic [7:0]       cmd,
  output logic [7:0]       status,
  output logic             prog_we,
  output logic             erase_start
);
  logic [7:0]       cmd_q, stat_q;
  logic [1:0]       cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       op;
  logic [7:0]       prog_fault;

  assign op         = wword[7:0];
  assign prog_fault = ro ? ST_PROG_ERR : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= OP_RD_ARRAY;
      cyc_q  <= 2'd0;
      stat_q <= ST_READY;
      cnt_q  <= '0;
    end else if (wr_acc) begin
      case (cyc_q)
        2'd0: begin
          case (op)
            OP_RD_ARRAY, OP_RD_ALT, OP_RESET: cmd_q <= OP_RD_ARRAY;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_q <= op;
              cyc_q <= 2'd1;
            end
            OP_ERASE: begin
              cmd_q  <= op;
              cyc_q  <= 2'd1;
              stat_q <= stat_q | ST_READY | (ro ? ST_ERASE_ERR : 8'h00);
            end
            OP_CLR: begin
              stat_q <= 8'h00;
              cmd_q  <= OP_RD_ARRAY;
            end
            OP_STAT, OP_IDENT: cmd_q <= op;
            OP_BUFWR: begin
              cmd_q  <= op;
              cyc_q  <= 2'd1;
              stat_q <= stat_q | ST_READY;
            end
            default: cmd_q <= OP_RD_ARRAY;
          endcase
        end
        2'd1: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              stat_q <= stat_q | ST_READY | prog_fault;
              cyc_q  <= 2'd0;
            end
            OP_ERASE, OP_ERASE_ALT: begin
              cyc_q <= 2'd0;
              if (op == OP_CONFIRM) stat_q <= stat_q | ST_READY;
              else                  cmd_q  <= OP_RD_ARRAY;
            end
            OP_BUFWR: begin
              cnt_q <= wword;
              cyc_q <= 2'd2;
            end
            OP_LOCK: begin
              cyc_q <= 2'd0;
              if (op == OP_CONFIRM || op == OP_LOCK_ALT) stat_q <= stat_q | ST_READY;
              else                                       cmd_q  <= OP_RD_ARRAY;
            end
            OP_QUERY: begin
              if (op == OP_RESET) begin
                cmd_q <= OP_RD_ARRAY;
                cyc_q <= 2'd0;
              end
            end
            default: begin
              cmd_q <= OP_RD_ARRAY;
              cyc_q <= 2'd0;
            end
          endcase
        end
        2'd2: begin
          if (cmd_q == OP_BUFWR) begin
            stat_q <= stat_q | ST_READY | prog_fault;
            if (cnt_q == '0) cyc_q <= 2'd3;
            else             cnt_q <= cnt_q - 1'b1;
          end else begin
            cmd_q <= OP_RD_ARRAY;
            cyc_q <= 2'd0;
          end
        end
        default: begin
          cyc_q <= 2'd0;
          if (cmd_q == OP_BUFWR && op == OP_CONFIRM) stat_q <= stat_q | ST_READY;
          else                                       cmd_q  <= OP_RD_ARRAY;
        end
      endcase
    end
  end

  assign prog_we = wr_acc && !ro &&
                   (((cyc_q == 2'd1) && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B)) ||
                    ((cyc_q == 2'd2) && (cmd_q == OP_BUFWR)));
  assign erase_start = wr_acc && !ro && (cyc_q == 2'd0) && (op == OP_ERASE);
  assign cmd    = cmd_q;
  assign status = stat_q;

  assert_unknown_op_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && cyc_q == 2'd0 && !known_opcode(op)) |=> (cmd_q == OP_RD_ARRAY && cyc_q == 2'd0));
  assert_clear_status_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && cyc_q == 2'd0 && op == OP_CLR) |=> (stat_q == 8'h00 && cmd_q == OP_RD_ARRAY));
  assert_ro_no_store_R3: assert property (@(posedge clk) disable iff (rst)
    ro |-> !prog_we);
  assert_buffer_last_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && cyc_q == 2'd2 && cmd_q == OP_BUFWR && cnt_q == '0) |=> (cyc_q == 2'd3));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int BLK_BYTES = 32,
  parameter int DEV_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ro_cfg,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              busy,
  output logic              qry_req,
  output logic              qry_sel,
  output logic [ADDR_W-1:0] qry_addr,
  input  logic [DATA_W-1:0] qry_data
);
  localparam int BYTES     = DATA_W / 8;
  localparam int BYTE_SH   = $clog2(BYTES);
  localparam int WA_W      = ADDR_W - BYTE_SH;
  localparam int BLK_WORDS = BLK_BYTES / BYTES;
  localparam int LANE      = (DEV_BYTES == 0) ? BYTES : DEV_BYTES;
  localparam int LANES     = BYTES / LANE;
  localparam int CNT_W     = LANE * 8;

  logic              wr_acc, rd_acc;
  logic [7:0]        cmd, status;
  logic              prog_we, erase_start, er_busy;
  logic [WA_W-1:0]   er_addr, word_addr;
  logic              arr_we;
  logic [WA_W-1:0]   arr_waddr;
  logic [DATA_W-1:0] arr_wd, arr_q;
  logic [DATA_W-1:0] stat_word, side_q;
  rsrc_t             mode, src_q;
  logic              rvalid_q;

  assign wr_acc    = wr_en && !er_busy;
  assign rd_acc    = rd_en && !er_busy;
  assign word_addr = addr[ADDR_W-1:BYTE_SH];

  nor_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .wword(wdata[CNT_W-1:0]),
    .ro(ro_cfg), .cmd(cmd), .status(status), .prog_we(prog_we),
    .erase_start(erase_start)
  );

  nor_erase_walker #(.AW(WA_W), .BLK_WORDS(BLK_WORDS)) u_erase (
    .clk(clk), .rst(rst), .start(erase_start), .start_addr(word_addr),
    .busy(er_busy), .wr_addr(er_addr)
  );

  assign arr_we    = er_busy || prog_we;
  assign arr_waddr = er_busy ? er_addr : word_addr;
  assign arr_wd    = er_busy ? {DATA_W{1'b1}} : wdata;

  nor_array #(.DATA_W(DATA_W), .AW(WA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wd),
    .re(rd_acc), .raddr(word_addr), .rdata(arr_q)
  );

  always_comb begin
    stat_word = '0;
    for (int g = 0; g < LANES; g++) stat_word[g*LANE*8 +: 8] = status;
  end

  always_comb begin
    if (shows_status(cmd))                       mode = RS_STATUS;
    else if (cmd == OP_IDENT || cmd == OP_QUERY) mode = RS_QUERY;
    else                                         mode = RS_ARRAY;
  end

  assign qry_req  = rd_acc && (mode == RS_QUERY);
  assign qry_sel  = (cmd == OP_QUERY);
  assign qry_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      src_q    <= RS_ARRAY;
      side_q   <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        src_q  <= mode;
        side_q <= (mode == RS_STATUS) ? stat_word : qry_data;
      end
    end
  end

  assign rdata  = (src_q == RS_ARRAY) ? arr_q : side_q;
  assign rvalid = rvalid_q;
  assign busy   = er_busy;

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rvalid_q == $past(rd_en && !er_busy && !rst));
  assert_erase_goes_busy_R4: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> er_busy);
  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (rst)
    er_busy |=> !rvalid_q);
endmodule

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int BLKW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, ro_cfg = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, qry_data;
  logic          rvalid, busy, qry_req, qry_sel;
  logic [AW-1:0] qry_addr;

  always #2.5 clk = ~clk;

  assign qry_data = qry_req ? {(qry_sel ? 8'hC0 : 8'h1D), qry_addr} : '0;

  nor_cmd_seq uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ro_cfg(ro_cfg), .rdata(rdata), .rvalid(rvalid),
    .busy(busy), .qry_req(qry_req), .qry_sel(qry_sel), .qry_addr(qry_addr),
    .qry_data(qry_data)
  );

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  // reference model state
  int m_cmd = 0, m_cyc = 0, m_stat = 8'h80, m_cnt = 0, m_left = 0;
  logic [DW-1:0] m_mem [0:127];
  logic          e_rvalid, e_busy;
  logic [DW-1:0] e_rdata;

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit stat_cmd(int c);
    return c == 8'h10 || c == 8'h20 || c == 8'h28 || c == 8'h40 ||
           c == 8'h50 || c == 8'h60 || c == 8'h70 || c == 8'hE8;
  endfunction

  task automatic model(bit we, bit re, int a, logic [DW-1:0] d);
    int op = d[7:0];
    int w  = a / 2;
    if (m_left > 0) begin
      m_left--;
      e_rvalid = 1'b0;
      e_busy   = (m_left > 0);
      return;
    end
    e_rvalid = re;
    if (re) begin
      if (stat_cmd(m_cmd))                    e_rdata = {m_stat[7:0], m_stat[7:0]};
      else if (m_cmd == 8'h90 || m_cmd == 8'h98) e_rdata = {(m_cmd == 8'h98) ? 8'hC0 : 8'h1D, a[7:0]};
      else                                    e_rdata = m_mem[w];
    end
    if (we) begin
      if (m_cyc == 0) begin
        if (op == 8'h00 || op == 8'hF0 || op == 8'hFF) m_cmd = 0;
        else if (op == 8'h10 || op == 8'h40 || op == 8'h60 || op == 8'h98) begin m_cmd = op; m_cyc = 1; end
        else if (op == 8'h20) begin
          m_cmd = op; m_cyc = 1; m_stat |= 8'h80;
          if (ro_cfg) m_stat |= 8'h20;
          else begin
            for (int i = 0; i < BLKW; i++) m_mem[(w / BLKW) * BLKW + i] = 16'hFFFF;
            m_left = BLKW;
          end
        end
        else if (op == 8'h50) begin m_stat = 0; m_cmd = 0; end
        else if (op == 8'h70 || op == 8'h90) m_cmd = op;
        else if (op == 8'hE8) begin m_cmd = op; m_cyc = 1; m_stat |= 8'h80; end
        else m_cmd = 0;
      end else if (m_cyc == 1) begin
        if (m_cmd == 8'h10 || m_cmd == 8'h40) begin
          if (ro_cfg) m_stat |= 8'h10; else m_mem[w] = d;
          m_stat |= 8'h80; m_cyc = 0;
        end else if (m_cmd == 8'h20) begin
          m_cyc = 0;
          if (op == 8'hD0) m_stat |= 8'h80; else m_cmd = 0;
        end else if (m_cmd == 8'hE8) begin
          m_cnt = d[7:0]; m_cyc = 2;
        end else if (m_cmd == 8'h60) begin
          m_cyc = 0;
          if (op == 8'hD0 || op == 8'h01) m_stat |= 8'h80; else m_cmd = 0;
        end else if (m_cmd == 8'h98) begin
          if (op == 8'hFF) begin m_cmd = 0; m_cyc = 0; end
        end
      end else if (m_cyc == 2) begin
        if (ro_cfg) m_stat |= 8'h10; else m_mem[w] = d;
        m_stat |= 8'h80;
        if (m_cnt == 0) m_cyc = 3; else m_cnt--;
      end else begin
        m_cyc = 0;
        if (op == 8'hD0) m_stat |= 8'h80; else m_cmd = 0;
      end
    end
    e_busy = (m_left > 0);
  endtask

  task automatic step(bit we, bit re, int a, logic [DW-1:0] d);
    wr_en = we; rd_en = re; addr = a[AW-1:0]; wdata = d;
    model(we, re, a, d);
    @(posedge clk);
    @(negedge clk);
    chk("busy", {15'b0, busy}, {15'b0, e_busy});
    chk("rvalid", {15'b0, rvalid}, {15'b0, e_rvalid});
    if (e_rvalid && !$isunknown(e_rdata)) chk("rdata", rdata, e_rdata);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(int a, logic [DW-1:0] d); step(1, 0, a, d); endtask
  task automatic rd(int a);                   step(0, 1, a, '0); endtask
  task automatic idle();                      step(0, 0, 0, '0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = 'x;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1"; idle(); wr(0, 16'h0070); rd(0);
    // R4 + R12: erase block 0, access during walk ignored
    cur_req = "R4"; wr(5, 16'h0020);
    cur_req = "R12"; rd(2); wr(2, 16'h0040);
    cur_req = "R4"; while (m_left > 0) idle();
    wr(0, 16'h00D0); rd(0); wr(0, 16'h00FF);
    for (int i = 0; i < 17; i++) rd(i * 2);
    // R3: programs
    cur_req = "R3"; wr(4, 16'h0040); wr(4, 16'h1234); rd(4);
    wr(0, 16'h0010); wr(6, 16'hABCD); wr(0, 16'h00FF); rd(4); rd(6);
    // R2: alternate read-array opcodes
    cur_req = "R2"; wr(0, 16'h0070); wr(0, 16'h00F0); rd(4);
    wr(0, 16'h0070); wr(0, 16'h0000); rd(6);
    // R3/R4 read-only faults
    ro_cfg = 1'b1;
    cur_req = "R3"; wr(8, 16'h0010); wr(8, 16'h5555); rd(0); wr(0, 16'h00FF); rd(8);
    cur_req = "R5"; wr(0, 16'h0050); rd(8); wr(0, 16'h0070); rd(0);
    cur_req = "R4"; wr(64, 16'h0020); rd(0); wr(64, 16'h00D0); rd(0);
    cur_req = "R9"; wr(32, 16'h00E8); wr(32, 16'h0000); wr(32, 16'h7777); rd(0);
    wr(0, 16'h00D0); wr(0, 16'h00FF); rd(32);
    ro_cfg = 1'b0;
    cur_req = "R5"; wr(0, 16'h0050); wr(0, 16'h0070); rd(0); wr(0, 16'h00FF);
    // R9: buffered writes, count masked to the device width
    cur_req = "R9"; wr(32, 16'h00E8); wr(32, 16'h0102);
    wr(32, 16'hA001); wr(34, 16'hA002); wr(36, 16'hA003); rd(0);
    wr(0, 16'h00D0); rd(0); wr(0, 16'h00FF); rd(32); rd(34); rd(36);
    wr(40, 16'h00E8); wr(40, 16'h0100); wr(40, 16'hB00B); wr(0, 16'h0033); rd(40); rd(42);
    // R6: status modes
    cur_req = "R6"; wr(0, 16'h0070); rd(10); wr(0, 16'h0050); wr(0, 16'h0070); rd(12); wr(0, 16'h00FF);
    // R8: lock sequences
    cur_req = "R8"; wr(0, 16'h0060); wr(0, 16'h00D0); rd(4);
    wr(0, 16'h0060); wr(0, 16'h0001); rd(4);
    wr(0, 16'h0060); wr(0, 16'h0033); rd(4);
    wr(0, 16'h0060); wr(0, 16'h00FF); rd(6);
    // R7: identify and query
    cur_req = "R7"; wr(0, 16'h0098); rd(34); wr(0, 16'h0012); rd(16);
    wr(0, 16'h00FF); rd(4); wr(0, 16'h0090); rd(2); rd(0); wr(0, 16'h00FF); rd(4);
    // R10: unknown opcode
    cur_req = "R10"; wr(0, 16'h0070); wr(0, 16'h0077); rd(4);
    // R4: erase aborted by a non-confirm byte
    cur_req = "R4"; wr(70, 16'h0020); while (m_left > 0) idle();
    wr(0, 16'h0033); rd(70); rd(64);
    // R11: back-to-back reads
    cur_req = "R11"; rd(4); rd(6); idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule